// File: doc/BRIEF.md
# Decimal 4221 Carry-Save Adder

This block reduces three decimal operands to two in one combinational step. Each operand is a vector of `DIGITS` decimal digits. Every 4-bit digit uses the 4-2-2-1 weighted code: bit 3 weighs 4, bits 2 and 1 weigh 2 each, and bit 0 weighs 1. Any of the sixteen bit patterns is a legal digit with a value from 0 to 9, so one value can have more than one encoding. The block returns a sum vector and a doubled-carry vector. Their decoded values add up to the decoded total of the three inputs. It is meant to be used as the basic cell of a decimal partial-product reduction tree.

Each digit position works in two steps. First, four independent full adders act on the bit columns and give a sum digit S and a carry digit H, both in 4221 code, so that A+B+C = S+2H. Second, H is recoded into the 5-2-1-1 weighted code and shifted left by one bit, which forms 2H. After the shift, the weight-5 bit becomes a decimal carry worth ten, and it moves into bit 0 of the next higher doubled digit. The least significant position receives a carry of zero. The carry out of the most significant position becomes one extra digit at the top of the doubled vector.

Top module: `dcsa4221_adder`

## Requirements
- R1: Every bit of `sum_o` is the XOR of the bits at the same position in `in_a`, `in_b` and `in_c`.
- R2: Decoding each digit as 4*b3+2*b2+2*b1+b0 with weights of ten between digits, value(`sum_o`) + value(`dbl_o`) equals value(`in_a`) + value(`in_b`) + value(`in_c`) for every input pattern, canonical or not.
- R3: Bit 0 of `dbl_o` is always 0, because no carry enters the least significant position.
- R4: Let H_i be the carry digit of position i, where each bit is 1 when at least two of the three input bits in that column are 1. Bit 0 of doubled digit i+1 is 1 exactly when the 4221 value of H_i is 5 or more.
- R5: The 4221 value of doubled digit i equals 2*value(H_i) - 10*carry_out_i + carry_in_i, where carry_in_i is bit 0 of that same digit.
- R6: The extra top digit of `dbl_o` (bits 4*DIGITS+3 down to 4*DIGITS) holds zeros in its upper three bits and the carry out of the most significant position in its bit 0.
- R7: All-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | 4*DIGITS | First operand, 4221 digits, digit 0 in bits 3:0 |
| in_b | input | 4*DIGITS | Second operand, 4221 digits |
| in_c | input | 4*DIGITS | Third operand, 4221 digits |
| sum_o | output | 4*DIGITS | Sum vector S, 4221 digits |
| dbl_o | output | 4*DIGITS+4 | Doubled-carry vector 2H, 4221 digits, one extra digit at the top |

## Verification
The lowest digit position is swept over all 4096 combinations of three 4-bit patterns. Because this sweep includes every non-canonical encoding, an error in the recoder or in the weighting of a column shows up as a mismatch in the value total. The upper digit is driven with patterns derived from the sweep index, so carries leave and enter it under many mixes of carry-in. A second sweep makes the carry digit equal to each of the sixteen patterns in turn (equal A and B, C at zero). This separates a wrong carry threshold or a wrong shifted digit value from errors on the sum side. An all-zero vector confirms the idle result.

// File: rtl/dcsa4221_pkg.sv
package dcsa4221_pkg;

  localparam int DIG_W = 4;

  typedef logic [DIG_W-1:0] digit_t;

  // value of a 4-2-2-1 weighted digit
  function automatic logic [3:0] val4221(digit_t d);
    logic [3:0] v;
    v = {1'b0, d[3], 2'b00} + {2'b00, d[2], 1'b0} + {2'b00, d[1], 1'b0} + {3'b000, d[0]};
    return v;
  endfunction

  // value of a 5-2-1-1 weighted digit
  function automatic logic [3:0] val5211(digit_t w);
    logic [3:0] v;
    v = (w[3] ? 4'd5 : 4'd0) + {2'b00, w[2], 1'b0} + {3'b000, w[1]} + {3'b000, w[0]};
    return v;
  endfunction

  // recode any 4221 pattern into a 5211 digit of equal value
  function automatic digit_t to5211(digit_t h);
    logic [3:0] v;
    logic [3:0] r;
    logic       hi;
    logic [2:0] lo;
    v  = val4221(h);
    hi = (v >= 4'd5);
    r  = hi ? (v - 4'd5) : v;
    case (r)
      4'd0:    lo = 3'b000;
      4'd1:    lo = 3'b001;
      4'd2:    lo = 3'b100;
      4'd3:    lo = 3'b101;
      default: lo = 3'b111;
    endcase
    return {hi, lo};
  endfunction

endpackage

// File: rtl/dcsa_fa_col.sv
module dcsa_fa_col (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic h_o
);
  logic ab_x;
  assign ab_x = a_i ^ b_i;
  assign s_o  = ab_x ^ c_i;
  // carry kept shallow: the recoder sits after it
  assign h_o  = (a_i & b_i) | (c_i & ab_x);
endmodule

// File: rtl/dcsa_digit_csa.sv
module dcsa_digit_csa
  import dcsa4221_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  input  digit_t c_i,
  output digit_t s_o,
  output digit_t h_o
);
  for (genvar k = 0; k < DIG_W; k++) begin : g_col
    dcsa_fa_col u_fa (
      .a_i(a_i[k]),
      .b_i(b_i[k]),
      .c_i(c_i[k]),
      .s_o(s_o[k]),
      .h_o(h_o[k])
    );
  end
endmodule

// File: rtl/dcsa_recode_5211.sv
module dcsa_recode_5211
  import dcsa4221_pkg::*;
(
  input  digit_t h_i,
  output digit_t w_o
);
  assign w_o = to5211(h_i);
endmodule

// File: rtl/dcsa_dbl_shift.sv
module dcsa_dbl_shift
  import dcsa4221_pkg::*;
(
  input  digit_t w_i,
  input  logic   cin_i,
  output digit_t d_o,
  output logic   cout_o
);
  // weight 5 doubles to ten and leaves; 2,1,1 double to 4,2,2
  assign d_o    = {w_i[2:0], cin_i};
  assign cout_o = w_i[3];
endmodule

// File: rtl/dcsa4221_adder.sv
module dcsa4221_adder
  import dcsa4221_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] in_a,
  input  logic [4*DIGITS-1:0] in_b,
  input  logic [4*DIGITS-1:0] in_c,
  output logic [4*DIGITS-1:0] sum_o,
  output logic [4*DIGITS+3:0] dbl_o
);
  localparam int VEC_W = DIG_W * DIGITS;
  localparam int DBL_W = VEC_W + DIG_W;

  logic [VEC_W-1:0] h_dig;
  logic [DIGITS:0]  dig_carry;

  assign dig_carry[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    digit_t w5211;

    dcsa_digit_csa u_csa (
      .a_i(in_a[DIG_W*g +: DIG_W]),
      .b_i(in_b[DIG_W*g +: DIG_W]),
      .c_i(in_c[DIG_W*g +: DIG_W]),
      .s_o(sum_o[DIG_W*g +: DIG_W]),
      .h_o(h_dig[DIG_W*g +: DIG_W])
    );

    dcsa_recode_5211 u_rec (
      .h_i(h_dig[DIG_W*g +: DIG_W]),
      .w_o(w5211)
    );

    dcsa_dbl_shift u_sh (
      .w_i   (w5211),
      .cin_i (dig_carry[g]),
      .d_o   (dbl_o[DIG_W*g +: DIG_W]),
      .cout_o(dig_carry[g+1])
    );
  end

  assign dbl_o[DBL_W-1 -: DIG_W] = {3'b000, dig_carry[DIGITS]};

endmodule

// File: rtl/dcsa4221_chk.sv
module dcsa4221_chk
  import dcsa4221_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input logic [4*DIGITS-1:0] in_a,
  input logic [4*DIGITS-1:0] in_b,
  input logic [4*DIGITS-1:0] in_c,
  input logic [4*DIGITS-1:0] sum_o,
  input logic [4*DIGITS+3:0] dbl_o,
  input logic [4*DIGITS-1:0] h_dig,
  input logic [DIGITS:0]     dig_carry
);
  function automatic logic [63:0] vec_val(logic [4*DIGITS+3:0] v, int n);
    logic [63:0] acc;
    logic [63:0] scale;
    acc   = 64'd0;
    scale = 64'd1;
    for (int i = 0; i < n; i++) begin
      acc   = acc + scale * 64'(val4221(v[4*i +: 4]));
      scale = scale * 64'd10;
    end
    return acc;
  endfunction

  always_comb begin
    if (!$isunknown({in_a, in_b, in_c, sum_o, dbl_o, h_dig, dig_carry})) begin
      assert_value_sum_R2: assert (
        vec_val({4'b0, sum_o}, DIGITS) + vec_val(dbl_o, DIGITS + 1) ==
        vec_val({4'b0, in_a}, DIGITS) + vec_val({4'b0, in_b}, DIGITS) +
        vec_val({4'b0, in_c}, DIGITS));
      assert_no_carry_in_R3: assert (dbl_o[0] == 1'b0);
      assert_top_digit_R6: assert (dbl_o[4*DIGITS +: 4] == {3'b000, dig_carry[DIGITS]});
      for (int i = 0; i < DIGITS; i++) begin
        assert_carry_rule_R4: assert (dig_carry[i+1] == (val4221(h_dig[4*i +: 4]) >= 4'd5));
        assert_dbl_digit_R5: assert (
          5'(val4221(dbl_o[4*i +: 4])) + (dig_carry[i+1] ? 5'd10 : 5'd0) ==
          5'({val4221(h_dig[4*i +: 4]), 1'b0}) + 5'(dig_carry[i]));
      end
    end
  end
endmodule

bind dcsa4221_adder dcsa4221_chk #(.DIGITS(DIGITS)) u_chk (
  .in_a     (in_a),
  .in_b     (in_b),
  .in_c     (in_c),
  .sum_o    (sum_o),
  .dbl_o    (dbl_o),
  .h_dig    (h_dig),
  .dig_carry(dig_carry)
);

// File: tb/test_dcsa4221_adder.sv
module test_dcsa4221_adder;
  localparam int N = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4*N-1:0] a, b, c;
  logic [4*N-1:0] s;
  logic [4*N+3:0] d;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  dcsa4221_adder #(.DIGITS(N)) i_dcsa4221_adder (
    .in_a(a), .in_b(b), .in_c(c), .sum_o(s), .dbl_o(d)
  );

  function automatic int wv(logic [3:0] x);
    return 4 * int'(x[3]) + 2 * int'(x[2]) + 2 * int'(x[1]) + int'(x[0]);
  endfunction

  function automatic int nv(logic [4*N+3:0] v, int n);
    int acc = 0;
    int sc  = 1;
    for (int i = 0; i < n; i++) begin
      acc = acc + sc * wv(v[4*i +: 4]);
      sc  = sc * 10;
    end
    return acc;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (a=%h b=%h c=%h)", req, act, exp, a, b, c);
    end
  endtask

  task automatic apply_and_check(logic [4*N-1:0] na, logic [4*N-1:0] nb, logic [4*N-1:0] nc);
    logic [3:0] h;
    int cin, cout, hv, lhs, rhs;
    @(posedge clk);
    a = na; b = nb; c = nc;
    @(negedge clk);
    // R1: per-bit XOR
    chk(s == (a ^ b ^ c), "R1", int'(s), int'(a ^ b ^ c));
    // R2: value conservation
    lhs = nv({4'b0, s}, N) + nv(d, N + 1);
    rhs = nv({4'b0, a}, N) + nv({4'b0, b}, N) + nv({4'b0, c}, N);
    chk(lhs == rhs, "R2", lhs, rhs);
    // R3
    chk(d[0] == 1'b0, "R3", int'(d[0]), 0);
    cin = 0;
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < 4; k++)
        h[k] = (int'(a[4*i+k]) + int'(b[4*i+k]) + int'(c[4*i+k])) >= 2;
      hv   = wv(h);
      cout = (hv >= 5) ? 1 : 0;
      // R4: carry into next digit
      chk(int'(d[4*(i+1)]) == cout, "R4", int'(d[4*(i+1)]), cout);
      // R5: doubled digit value
      chk(wv(d[4*i +: 4]) == 2*hv - 10*cout + cin, "R5", wv(d[4*i +: 4]), 2*hv - 10*cout + cin);
      cin = cout;
    end
    // R6: top digit
    chk(d[4*N +: 4] == 4'(cin), "R6", int'(d[4*N +: 4]), cin);
  endtask

  initial begin
    a = '0; b = '0; c = '0;
    // R7: all-zero inputs
    @(posedge clk);
    @(negedge clk);
    chk(s == '0, "R7", int'(s), 0);
    chk(d == '0, "R7", int'(d), 0);

    // exhaustive low digit, index-derived high digit
    for (int idx = 0; idx < 4096; idx++) begin
      logic [11:0] x;
      x = 12'(idx);
      apply_and_check({x[11:8] ^ 4'h5, x[3:0]},
                      {x[3:0] + x[7:4], x[7:4]},
                      {~x[7:4], x[11:8]});
    end

    // carry digit driven through each of the sixteen patterns
    for (int p = 0; p < 16; p++) begin
      apply_and_check({4'h0, 4'(p)}, {4'h0, 4'(p)}, '0);
      apply_and_check({4'(p), 4'hF}, {4'(p), 4'hF}, {4'h0, 4'hF});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule